// File: doc/BRIEF.md
# Prioritized Supply Source Selector

This block watches three supply inputs and decides which one powers the system. Each input arrives as a digitized voltage sample in millivolts. The block checks each sample on its own against an acceptance window with a lower and an upper limit. An input counts as qualified only after it has stayed inside that window for an unbroken run of millisecond ticks. It loses that status on the first clock edge after it leaves the window.

The three inputs have a fixed rank. Input 0 is the network-fed supply and ranks highest. Input 1 is the external DC jack. Input 2 is the battery and ranks lowest. The block drives a one-hot select toward the highest-ranked qualified input. When the choice changes from one source to another, the select is held all-zero for one cycle before the new source is driven.

The block also provides:
- an active-low valid flag for each input;
- a charger-enable flag, raised while either non-battery input is qualified;
- a 2-bit source code that software can read.

Top module: `src_priority_sel`

## Requirements
- R1: An input sample is inside the window when LO_MV <= sample <= HI_MV, with defaults of 4700 and 5300 mV. Both limits are inclusive. One millivolt below the low limit, or one above the high limit, is outside.
- R2: An input qualifies on the clock edge of its QUAL_MS-th `ms_tick` counted while it is continuously inside the window. Cycles without a tick do not advance the count.
- R3: Once an input is outside the window at a clock edge, its valid flag is high after that edge and its tick count is cleared. A later return needs a full QUAL_MS ticks to qualify again.
- R4: Each input qualifies independently. The level of one input never changes the valid flag or the timer of another.
- R5: `src_sel` is one-hot or zero. One cycle after qualification changes, it points at the lowest-index qualified input (0 over 1 over 2).
- R6: `chg_en` is high exactly while input 0 or input 1 is qualified, in the same cycle as their valid flags. The battery input has no effect on it.
- R7: `src_code` is registered together with `src_sel`. It reads 0 for no source, and i+1 when bit i of `src_sel` is set.
- R8: When the selected source moves from one input to a different input, `src_sel` is all-zero for exactly one cycle before the new bit is set.
- R9: With no input qualified, `src_sel` is 0 and `src_code` is 0, one cycle later.
- R10: During and after reset, every `vld_n` bit is high and `src_sel`, `src_code` and `chg_en` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| in_mv | input | N_IN*MV_W | Packed voltage samples in mV; input i occupies bits [i*MV_W +: MV_W] |
| vld_n | output | N_IN | Active-low qualified flag per input |
| src_sel | output | N_IN | One-hot selected source, zero when none |
| src_code | output | CODE_W | 0 = none, i+1 = input i selected |
| chg_en | output | 1 | Charger enable, from inputs 0 and 1 only |

## Verification
The bench runs with the qualification period shortened to four ticks. It sweeps all eight in-window/out-of-window patterns of the three inputs. Out-of-window inputs alternate between under- and over-voltage, which separates the priority pick, the battery-only case and the no-source case.

A boundary sweep places a single input at one millivolt on each side of both limits. This tells an inclusive window apart from an exclusive one. Two further runs cover the qualification timer:
- a one-cycle excursion during qualification, which shows whether the timer restarts or only pauses;
- a stretch with no ticks, which shows whether the timer counts clock cycles instead of ticks.

A promotion from the external input to the network input exposes the idle cycle of the source changeover. A cycle-level model in the bench checks every output after every clock.

// File: rtl/psel_pkg.sv
package psel_pkg;
   localparam int PSEL_N_IN = 3;
   localparam int PSEL_CODE_W = $clog2(PSEL_N_IN + 1);
   typedef logic [PSEL_CODE_W-1:0] psel_code_t;
   localparam psel_code_t PSEL_CODE_NONE = '0;
endpackage

// File: rtl/psel_window_qual.sv
module psel_window_qual #(
   parameter int MV_W    = 13,
   parameter int LO_MV   = 4700,
   parameter int HI_MV   = 5300,
   parameter int QUAL_MS = 256
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            ms_tick,
   input  logic [MV_W-1:0] mv,
   output logic            qual
);
   localparam int CNT_W = (QUAL_MS > 2) ? $clog2(QUAL_MS) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_MS - 1);

   generate
      if (QUAL_MS < 2) begin : g_bad_period
         $error("QUAL_MS must be at least 2");
      end
      if (LO_MV > HI_MV) begin : g_bad_window
         $error("LO_MV must not exceed HI_MV");
      end
      if (HI_MV >= (1 << MV_W)) begin : g_bad_width
         $error("HI_MV does not fit in MV_W bits");
      end
   endgenerate

   logic             in_win;
   logic [CNT_W-1:0] cnt;

   assign in_win = (int'(mv) >= LO_MV) && (int'(mv) <= HI_MV);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         qual <= 1'b0;
      end else if (!in_win) begin
         cnt  <= '0;
         qual <= 1'b0;
      end else if (!qual && ms_tick) begin
         if (cnt == CNT_LAST) begin
            qual <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_DROP_ON_EXIT: assert property (@(posedge clk) disable iff (rst)
      !in_win |=> !qual) else $error("qual held after leaving window"); // R3
   AST_RISE_NEEDS_WIN: assert property (@(posedge clk) disable iff (rst)
      $rose(qual) |-> $past(in_win) && $past(ms_tick)) else $error("qual rose without tick in window"); // R2
   AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
      !in_win |=> cnt == '0) else $error("timer not cleared"); // R3
endmodule

// File: rtl/psel_arbiter.sv
module psel_arbiter
   import psel_pkg::*;
#(
   parameter int N_IN   = PSEL_N_IN,
   parameter int CODE_W = $clog2(N_IN + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [N_IN-1:0]   qual,
   output logic [N_IN-1:0]   sel,
   output logic [CODE_W-1:0] code
);
   logic [N_IN-1:0]   want;
   logic [N_IN-1:0]   sel_nxt;
   logic [CODE_W-1:0] code_nxt;

   always_comb begin
      want = '0;
      for (int i = N_IN - 1; i >= 0; i--) begin
         if (qual[i]) want = N_IN'(1) << i;
      end
   end

   always_comb begin
      if (want == sel)        sel_nxt = sel;
      else if (sel != '0)     sel_nxt = '0;
      else                    sel_nxt = want;
   end

   always_comb begin
      code_nxt = '0;
      for (int i = 0; i < N_IN; i++) begin
         if (sel_nxt[i]) code_nxt = CODE_W'(i + 1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sel  <= '0;
         code <= '0;
      end else begin
         sel  <= sel_nxt;
         code <= code_nxt;
      end
   end

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sel)) else $error("select not one-hot"); // R5
   AST_BREAK_FIRST: assert property (@(posedge clk) disable iff (rst)
      (sel != '0 && $past(sel) != '0) |-> sel == $past(sel)) else $error("make before break"); // R8
   AST_LOWEST_NEEDS_ALONE: assert property (@(posedge clk) disable iff (rst)
      sel[N_IN-1] |-> $past(qual[N_IN-2:0]) == '0) else $error("low rank picked over higher"); // R5
   AST_CODE_NONE: assert property (@(posedge clk) disable iff (rst)
      (code == '0) == (sel == '0)) else $error("code and select disagree"); // R7
   AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
      $past(qual) == '0 |-> sel == '0) else $error("source selected with none valid"); // R9
endmodule

// File: rtl/src_priority_sel.sv
module src_priority_sel
   import psel_pkg::*;
#(
   parameter int          N_IN     = PSEL_N_IN,
   parameter int          MV_W     = 13,
   parameter int          LO_MV    = 4700,
   parameter int          HI_MV    = 5300,
   parameter int          QUAL_MS  = 256,
   parameter logic [N_IN-1:0] CHG_MASK = N_IN'(3),
   parameter int          CODE_W   = $clog2(N_IN + 1)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ms_tick,
   input  logic [N_IN*MV_W-1:0] in_mv,
   output logic [N_IN-1:0]      vld_n,
   output logic [N_IN-1:0]      src_sel,
   output logic [CODE_W-1:0]    src_code,
   output logic                 chg_en
);
   generate
      if (N_IN < 2) begin : g_bad_n
         $error("N_IN must be at least 2");
      end
      if (CODE_W < $clog2(N_IN + 1)) begin : g_bad_code
         $error("CODE_W too narrow");
      end
   endgenerate

   logic [N_IN-1:0] qual;

   generate
      for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
         psel_window_qual #(
            .MV_W   (MV_W),
            .LO_MV  (LO_MV),
            .HI_MV  (HI_MV),
            .QUAL_MS(QUAL_MS)
         ) u_qual (
            .clk    (clk),
            .rst    (rst),
            .ms_tick(ms_tick),
            .mv     (in_mv[gi*MV_W +: MV_W]),
            .qual   (qual[gi])
         );
      end
   endgenerate

   assign vld_n  = ~qual;
   assign chg_en = |(qual & CHG_MASK);

   psel_arbiter #(
      .N_IN  (N_IN),
      .CODE_W(CODE_W)
   ) u_arb (
      .clk (clk),
      .rst (rst),
      .qual(qual),
      .sel (src_sel),
      .code(src_code)
   );

   AST_CHG_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (rst)
      chg_en == ((~vld_n & CHG_MASK) != '0)) else $error("charger flag mismatch"); // R6
endmodule

// File: tb/src_priority_sel_tb.sv
module src_priority_sel_tb;
   localparam int N = 3;
   localparam int W = 13;
   localparam int Q = 4;
   localparam int LO = 4700;
   localparam int HI = 5300;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           ms_tick = 1'b0;
   logic [N*W-1:0] in_mv = '0;
   logic [N-1:0]   vld_n;
   logic [N-1:0]   src_sel;
   logic [1:0]     src_code;
   logic           chg_en;

   int nchk = 0;
   int nbad = 0;

   int v[N];
   int cnt_m[N];
   bit q_m[N];
   int sel_m;
   int code_m;

   always #2.5 clk = ~clk;

   src_priority_sel #(.N_IN(N), .MV_W(W), .LO_MV(LO), .HI_MV(HI), .QUAL_MS(Q)) u_dut (
      .clk(clk), .rst(rst), .ms_tick(ms_tick), .in_mv(in_mv),
      .vld_n(vld_n), .src_sel(src_sel), .src_code(src_code), .chg_en(chg_en)
   );

   task automatic chk(string tag, int act, int exp);
      nchk++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic drive();
      for (int i = 0; i < N; i++) in_mv[i*W +: W] = W'(v[i]);
   endtask

   function automatic int vld_exp();
      int r = 0;
      for (int i = 0; i < N; i++) if (!q_m[i]) r |= (1 << i);
      return r;
   endfunction

   task automatic step(bit tk);
      int want;
      drive();
      ms_tick = tk;
      @(posedge clk);
      want = 0;
      for (int i = N - 1; i >= 0; i--) if (q_m[i]) want = 1 << i;
      if (want != sel_m) sel_m = (sel_m != 0) ? 0 : want;
      code_m = (sel_m == 1) ? 1 : (sel_m == 2) ? 2 : (sel_m == 4) ? 3 : 0;
      for (int i = 0; i < N; i++) begin
         if (v[i] < LO || v[i] > HI) begin
            cnt_m[i] = 0;
            q_m[i] = 0;
         end else if (!q_m[i] && tk) begin
            if (cnt_m[i] == Q - 1) q_m[i] = 1;
            else cnt_m[i]++;
         end
      end
      @(negedge clk);
      ms_tick = 1'b0;
      chk("R3 vld_n", int'(vld_n), vld_exp());
      chk("R5 src_sel", int'(src_sel), sel_m);
      chk("R7 src_code", int'(src_code), code_m);
      chk("R6 chg_en", int'(chg_en), int'(q_m[0] | q_m[1]));
   endtask

   task automatic run(int n, bit tk);
      for (int k = 0; k < n; k++) step(tk);
   endtask

   initial begin
      #(5 * 150000);
      nbad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         v[i] = 0;
         cnt_m[i] = 0;
         q_m[i] = 0;
      end
      sel_m = 0;
      code_m = 0;
      drive();
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 vld_n", int'(vld_n), 7);
      chk("R10 src_sel", int'(src_sel), 0);
      chk("R10 src_code", int'(src_code), 0);
      chk("R10 chg_en", int'(chg_en), 0);
      rst = 1'b0;
      run(2, 1'b1);

      // R4 exhaustive in/out patterns, R5 priority, R9 none
      for (int p = 0; p < 8; p++) begin
         for (int i = 0; i < N; i++)
            v[i] = p[i] ? 5000 : (((p + i) % 2 == 0) ? 4600 : 5400);
         run(Q + 4, 1'b1);
         chk("R4 vld_n pattern", int'(vld_n), 7 & ~p);
         chk("R5 priority", int'(src_sel), p[0] ? 1 : p[1] ? 2 : p[2] ? 4 : 0);
         if (p == 0) begin
            chk("R9 no source sel", int'(src_sel), 0);
            chk("R9 no source code", int'(src_code), 0);
         end
         if (p == 4) chk("R6 battery only", int'(chg_en), 0);
      end

      // R1 boundaries on input 2, others out
      v[0] = 0; v[1] = 0;
      for (int b = 0; b < 4; b++) begin
         int val;
         val = (b == 0) ? LO - 1 : (b == 1) ? LO : (b == 2) ? HI : HI + 1;
         v[2] = val;
         run(Q + 2, 1'b1);
         chk("R1 window edge", int'(vld_n[2]), (b == 1 || b == 2) ? 0 : 1);
         v[2] = 0;
         run(2, 1'b1);
      end

      // R2 ticks only count, R3 excursion restarts timer
      v[0] = 0; v[1] = 0; v[2] = 0;
      run(2, 1'b1);
      v[1] = 5000;
      run(3 * Q, 1'b0);
      chk("R2 no tick no qual", int'(vld_n[1]), 1);
      run(Q - 1, 1'b1);
      v[1] = 4000;
      step(1'b0);
      chk("R3 exit while counting", int'(vld_n[1]), 1);
      v[1] = 5000;
      run(Q - 1, 1'b1);
      chk("R3 restart full period", int'(vld_n[1]), 1);
      step(1'b1);
      chk("R2 qualified on last tick", int'(vld_n[1]), 0);
      run(2, 1'b0);
      chk("R5 external selected", int'(src_sel), 2);

      // R8 promotion from input 1 to input 0
      v[0] = 5000;
      run(Q, 1'b1);
      chk("R4 neighbour flag", int'(vld_n), 4);
      step(1'b0);
      chk("R8 idle cycle", int'(src_sel), 0);
      chk("R8 idle code", int'(src_code), 0);
      step(1'b0);
      chk("R8 new source", int'(src_sel), 1);
      chk("R7 code one", int'(src_code), 1);

      // R3 immediate drop, fallback through idle
      v[0] = 5400;
      step(1'b0);
      chk("R3 drop next edge", int'(vld_n[0]), 1);
      step(1'b0);
      chk("R8 idle on fallback", int'(src_sel), 0);
      step(1'b0);
      chk("R7 code two", int'(src_code), 2);

      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule